// File: doc/BRIEF.md
# Latching Input Change Interrupt

This block watches a small group of port inputs and tells a host when any of them has moved. Each input first crosses into the clock domain through a two-stage synchronizer. It is then compared every cycle against a stored copy of the levels that were seen at the last serial access. A mismatch on a port that is configured as an input (its output latch holds 1) sets a sticky change flag for that port. The same mismatch pulls an active-low interrupt output low and holds it there. Because the flags are sticky, a change that lasts a single clock is still remembered.

The serial interface tells the block when an access to the device is being acknowledged, when a read transfer is in progress, and when a STOP is seen. On each acknowledge, the block copies the live inputs into the stored copy, clears the flags and releases the interrupt. It also captures the flags it had just before the clear, so that they can be shifted out as the flag byte of the read.

While a read is in progress, a change is recorded but the interrupt stays released. At STOP the interrupt is raised only if some change is still unreported. If a later acknowledge in the same read already picked the change up, no interrupt follows.

Top module: `pchg_latch_irq`

## Requirements
- R1: After reset (rst_n low), irq_n is 1 and rd_flags is 0. The stored copy and both synchronizer stages take the value all ones, so an input held at all ones raises no flag when reset is released.
- R2: Outside a read (rd_active = 0), a change on a port whose od_latch bit is 1 drives irq_n low. irq_n goes low on the third rising clock edge after the new level is present on port_in, and it stays low until an acknowledge.
- R3: A port whose od_latch bit is 0 is ignored. A change on it sets no flag and does not drive irq_n low.
- R4: Flags are sticky. An input pulse lasting one clock that returns to its stored level still leaves its flag set and irq_n low.
- R5: A cycle with acc_ack = 1 has four effects at the next edge. It releases irq_n to 1. It loads rd_flags with the accumulated flags, with bit i standing for port_in[i]. It clears the flags. It loads the live inputs into the stored copy, so an input that stays at its new level raises no further flag.
- R6: While rd_active = 1 and stop_det = 0, irq_n does not fall. A change is still recorded in the flags.
- R7: In a cycle with stop_det = 1 and no acknowledge, if any flag is set or a change is seen in that cycle, irq_n goes low at the next edge.
- R8: If an acknowledge during a read has already cleared the flags and no new change follows, a STOP leaves irq_n at 1.
- R9: A change that reaches the comparison in the very cycle of an acknowledge is reported in rd_flags. After that acknowledge, irq_n stays released.
- R10: When acc_ack and stop_det are both 1 in the same cycle, the acknowledge wins. irq_n is 1 after that edge, and rd_flags holds the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| port_in | input | 4 | Raw port levels, not yet synchronized |
| od_latch | input | 4 | Output latch per port; 1 marks the port as an input |
| acc_ack | input | 1 | One-cycle strobe on the acknowledge of an access to the device |
| rd_active | input | 1 | High while a read transfer is in progress |
| stop_det | input | 1 | One-cycle strobe when a STOP is seen |
| rd_flags | output | 4 | Flags captured at the last acknowledge, for the flag byte |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
Two pairs of events can land in the same cycle.

The first pair is an input change and an acknowledge. The bench times a port edge so that its synchronized level reaches the comparison exactly in the acknowledge cycle. It then checks two things: the change shows up in rd_flags, and irq_n stays high afterwards.

The second pair is an acknowledge and a STOP, strobed together after a change during a read. Here the bench checks that the release wins over the held assertion.

Both cases are judged at the ports, one cycle after the edge and again a few cycles later.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
  localparam int unsigned PORTS = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
  parameter int unsigned W = pchg_pkg::PORTS,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned N = pchg_pkg::SYNC_STAGES;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] stg_q;
    logic [N-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[N-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {N{RST_VAL[b]}};
      else        stg_q <= stg_d;
    end

    assign q[b] = stg_q[N-1];
  end
endmodule

// File: rtl/pchg_track.sv
module pchg_track #(
  parameter int unsigned W = pchg_pkg::PORTS,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic [W-1:0] in_mask,
  input  logic         acc_ack,
  output logic         change_now,
  output logic         flag_pend,
  output logic [W-1:0] rd_flags
);
  logic [W-1:0] snap_q, snap_d;
  logic [W-1:0] fl_q, fl_d;
  logic [W-1:0] rdf_q, rdf_d;
  logic [W-1:0] diff;
  logic         snap_en, rdf_en;

  always_comb begin
    diff    = (live ^ snap_q) & in_mask;
    snap_en = acc_ack;
    rdf_en  = acc_ack;
    snap_d  = live;
    rdf_d   = fl_q | diff;
    fl_d    = acc_ack ? '0 : (fl_q | diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= INIT;
      fl_q   <= '0;
      rdf_q  <= '0;
    end else begin
      fl_q <= fl_d;
      if (snap_en) snap_q <= snap_d;
      if (rdf_en)  rdf_q  <= rdf_d;
    end
  end

  assign change_now = |diff;
  assign flag_pend  = |fl_q;
  assign rd_flags   = rdf_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ack |=> ((fl_q & $past(fl_q)) == $past(fl_q)));  // R4
  AST_MASKED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ack |=> ((fl_q & ~$past(fl_q) & ~$past(in_mask)) == '0));  // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> (fl_q == '0));  // R5
endmodule

// File: rtl/pchg_irq.sv
module pchg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_ack,
  input  logic rd_active,
  input  logic stop_det,
  input  logic change_now,
  input  logic flag_pend,
  output logic irq_q
);
  logic irq_d;
  logic set_now, set_stop;

  always_comb begin
    set_now  = change_now && !rd_active;
    set_stop = stop_det && (flag_pend || change_now);
    if (acc_ack)                  irq_d = 1'b0;
    else if (set_now || set_stop) irq_d = 1'b1;
    else                          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> !irq_q);  // R5
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && !stop_det) |=> !$rose(irq_q));  // R6
  AST_STOP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !acc_ack && flag_pend) |=> irq_q);  // R7
  AST_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (change_now && !rd_active && !acc_ack) |=> irq_q);  // R2
endmodule

// File: rtl/pchg_latch_irq.sv
module pchg_latch_irq #(
  parameter int unsigned W = pchg_pkg::PORTS,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_in,
  input  logic [W-1:0] od_latch,
  input  logic         acc_ack,
  input  logic         rd_active,
  input  logic         stop_det,
  output logic [W-1:0] rd_flags,
  output logic         irq_n
);
  logic [W-1:0] live;
  logic         change_now, flag_pend, irq_q;

  pchg_sync #(.W(W), .RST_VAL(INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(live)
  );

  pchg_track #(.W(W), .INIT(INIT)) u_track (
    .clk(clk), .rst_n(rst_n), .live(live), .in_mask(od_latch),
    .acc_ack(acc_ack), .change_now(change_now), .flag_pend(flag_pend),
    .rd_flags(rd_flags)
  );

  pchg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .acc_ack(acc_ack), .rd_active(rd_active),
    .stop_det(stop_det), .change_now(change_now), .flag_pend(flag_pend),
    .irq_q(irq_q)
  );

  assign irq_n = ~irq_q;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && rd_flags == '0));  // R1
endmodule

// File: tb/pchg_latch_irq_tb.sv
module pchg_latch_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] port_in, od_latch, rd_flags;
  logic       acc_ack, rd_active, stop_det, irq_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pchg_latch_irq u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .od_latch(od_latch),
    .acc_ack(acc_ack), .rd_active(rd_active), .stop_det(stop_det),
    .rd_flags(rd_flags), .irq_n(irq_n)
  );

  // {od_latch, port_in, expected irq_n, expected rd_flags}
  localparam logic [12:0] VEC [7] = '{
    {4'hF, 4'hE, 1'b0, 4'h1},
    {4'hF, 4'hE, 1'b1, 4'h0},
    {4'h3, 4'h6, 1'b1, 4'h0},
    {4'h3, 4'h5, 1'b0, 4'h3},
    {4'hF, 4'hA, 1'b0, 4'hF},
    {4'hC, 4'h9, 1'b1, 4'h0},
    {4'hC, 4'h5, 1'b0, 4'hC}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk) acc_ack = 1'b1;
    @(negedge clk) acc_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_in = 4'hF; od_latch = 4'hF;
    acc_ack = 1'b0; rd_active = 1'b0; stop_det = 1'b0;
    wait_cyc(3);
    check("R1 irq_n after reset", {3'b0, irq_n}, 4'h1);
    check("R1 rd_flags after reset", rd_flags, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);
    check("R1 idle after release", {3'b0, irq_n}, 4'h1);

    // table walk: R2, R3, R5
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      od_latch = VEC[i][12:9];
      port_in  = VEC[i][8:5];
      wait_cyc(4);
      check($sformatf("R2/R3 vec%0d irq_n", i), {3'b0, irq_n}, {3'b0, VEC[i][4]});
      do_ack();
      check($sformatf("R5 vec%0d released", i), {3'b0, irq_n}, 4'h1);
      check($sformatf("R5/R3 vec%0d rd_flags", i), rd_flags, VEC[i][3:0]);
    end

    // R2 latency: 5 -> D, bit3
    od_latch = 4'hF;
    @(negedge clk) port_in = 4'hD;
    wait_cyc(2);
    check("R2 not yet after two edges", {3'b0, irq_n}, 4'h1);
    wait_cyc(1);
    check("R2 low on third edge", {3'b0, irq_n}, 4'h0);
    do_ack();
    check("R5 flags bit3", rd_flags, 4'h8);
    wait_cyc(3);
    check("R5 stable input no new irq", {3'b0, irq_n}, 4'h1);

    // R4: one-clock pulse on bit2
    @(negedge clk) port_in = 4'h9;
    @(negedge clk) port_in = 4'hD;
    wait_cyc(5);
    check("R4 pulse holds irq", {3'b0, irq_n}, 4'h0);
    do_ack();
    check("R4 pulse flag", rd_flags, 4'h4);

    // R6/R7: change during read, raised at STOP
    @(negedge clk) rd_active = 1'b1; port_in = 4'hC;
    wait_cyc(6);
    check("R6 no irq during read", {3'b0, irq_n}, 4'h1);
    @(negedge clk) stop_det = 1'b1; rd_active = 1'b0;
    @(negedge clk) stop_det = 1'b0;
    check("R7 irq at STOP", {3'b0, irq_n}, 4'h0);
    do_ack();
    check("R7 flags", rd_flags, 4'h1);

    // R8: change read out before STOP
    @(negedge clk) rd_active = 1'b1; port_in = 4'hD;
    wait_cyc(5);
    do_ack();
    check("R8 flag read in read", rd_flags, 4'h1);
    wait_cyc(2);
    @(negedge clk) stop_det = 1'b1; rd_active = 1'b0;
    @(negedge clk) stop_det = 1'b0;
    wait_cyc(3);
    check("R8 no irq after STOP", {3'b0, irq_n}, 4'h1);

    // R9: change reaches compare in the ack cycle
    @(negedge clk) port_in = 4'hF;
    @(negedge clk);
    @(negedge clk) acc_ack = 1'b1;
    @(negedge clk) acc_ack = 1'b0;
    check("R9 flags in same-cycle ack", rd_flags, 4'h2);
    check("R9 irq released", {3'b0, irq_n}, 4'h1);
    wait_cyc(4);
    check("R9 irq stays released", {3'b0, irq_n}, 4'h1);

    // R10: ack and STOP together
    @(negedge clk) rd_active = 1'b1; port_in = 4'hD;
    wait_cyc(5);
    @(negedge clk) acc_ack = 1'b1; stop_det = 1'b1; rd_active = 1'b0;
    @(negedge clk) acc_ack = 1'b0; stop_det = 1'b0;
    check("R10 ack wins irq", {3'b0, irq_n}, 4'h1);
    check("R10 flags", rd_flags, 4'h2);
    wait_cyc(3);
    check("R10 irq stays released", {3'b0, irq_n}, 4'h1);

    // R1: reset while interrupt active
    @(negedge clk) port_in = 4'hC;
    wait_cyc(5);
    check("R1 pre-reset irq low", {3'b0, irq_n}, 4'h0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset releases irq", {3'b0, irq_n}, 4'h1);
    check("R1 reset clears rd_flags", rd_flags, 4'h0);
    port_in = 4'hF;
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);
    check("R1 no flag after release", {3'b0, irq_n}, 4'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule